// File: doc/BRIEF.md
# Asynchronous Copy Group Dependency Tracker

This block follows asynchronous global-to-shared copies for every warp of a core and stalls a warp that is waiting on them. The issue stage reports three kinds of event: a copy with its warp, a completion tag (program counter and first address folded together), an active mask and the number of memory requests it generates; a group commit, which closes the warp's currently open group; and a group wait carrying an allowed-pending count N. The memory system reports each returning request with its warp and tag.

A wait keeps the warp stalled until every group older than the N most recently committed groups has drained. The open group, which has not been committed yet, never counts against a wait. The scheduler reads the per-warp stall vector and treats a flagged warp as not eligible for issue. Copies with no active lanes never reach the table. A copy that finds its warp's table full is refused through a back-pressure output and must be presented again.

Top module: `async_copy_dep_tracker`

## Requirements
- R1: While `rst` is high at a clock edge, all tables, group counters and wait marks are cleared, and after that edge `stall` and `rt_err` are 0 and `cp_full` is 0 for any copy.
- R2: An accepted copy joins its warp's open group, whose index is the number of commits that warp has made. A commit moves later copies into a new group, and a wait with N = 0 never monitors the open group.
- R3: A wait with count N monitors every group of that warp whose index is below (commit count − N). If any monitored copy is outstanding, the warp's `stall` bit is 1 from the cycle after the wait.
- R4: If no monitored copy is outstanding when the wait issues, for example because N is not smaller than the number of committed groups, the `stall` bit stays 0.
- R5: A copy with an all-zero `cp_mask` or a zero `cp_reqs` is complete at issue. It stores nothing, never holds a wait, and never raises `cp_full`.
- R6: A return is matched within its warp on the full tag. Each matching return takes one from that copy's outstanding request count, and the copy is complete only when the count reaches zero.
- R7: After a return, the pending wait of that warp is re-evaluated, and `stall` falls in the cycle after the return that completes the last monitored copy.
- R8: `cp_full` is 1, combinationally, when a copy with nonzero mask and requests targets a warp whose ENTRIES slots are all in use at the start of the cycle. Such a copy is not recorded.
- R9: A return whose tag matches no outstanding copy of its warp sets `rt_err` to 1 for the following cycle.
- R10: Warps are independent: the events of one warp never change another warp's stall bit or table.
- R11: Events in one cycle take effect in the order return, copy, commit, wait. A copy and a commit followed by a wait with N = 0 in the same cycle therefore monitor that copy.
- R12: Group indices wrap modulo 2^GRP_W with wrap-aware age comparison. Results stay correct over any number of commits as long as the outstanding group span of a warp stays below 2^(GRP_W−1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cp_valid | input | 1 | A copy issues this cycle |
| cp_warp | input | WID_W | Warp of the copy |
| cp_tag | input | TAG_W | Completion tag of the copy |
| cp_mask | input | LANES | Active lanes of the copy |
| cp_reqs | input | CNT_W | Number of memory requests the copy generates |
| cm_valid | input | 1 | A group commit issues this cycle |
| cm_warp | input | WID_W | Warp of the commit |
| wt_valid | input | 1 | A group wait issues this cycle |
| wt_warp | input | WID_W | Warp of the wait |
| wt_n | input | GRP_W-1 | Number of recent committed groups allowed to stay pending |
| rt_valid | input | 1 | A memory return arrives this cycle |
| rt_warp | input | WID_W | Warp of the return |
| rt_tag | input | TAG_W | Tag of the return |
| cp_full | output | 1 | Copy refused: the warp's table is full |
| stall | output | NUM_WARPS | Per-warp wait stall flag |
| rt_err | output | 1 | The previous cycle's return matched nothing |

## Verification
The hardest state to reach is a wait whose monitored boundary lies across the wrap of the group index while older copies are still outstanding. A single warp has to commit more groups than the index can hold without letting its in-flight span grow too wide. The bench drives one warp through a long loop of copy, commit, wait and return, so the wait boundary crosses zero many times. A random phase then keeps the span bounded by refusing commits that would widen it, while returns drain entries in random order across warps.

// File: rtl/async_copy_dep_tracker.sv
module async_copy_dep_tracker #(
  parameter int NUM_WARPS = 4,
  parameter int ENTRIES   = 8,
  parameter int LANES     = 4,
  parameter int TAG_W     = 12,
  parameter int CNT_W     = 3,
  parameter int GRP_W     = 5,
  localparam int WID_W    = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
  localparam int SLOTS    = NUM_WARPS * ENTRIES,
  localparam int IDX_W    = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cp_valid,
  input  logic [WID_W-1:0]     cp_warp,
  input  logic [TAG_W-1:0]     cp_tag,
  input  logic [LANES-1:0]     cp_mask,
  input  logic [CNT_W-1:0]     cp_reqs,
  input  logic                 cm_valid,
  input  logic [WID_W-1:0]     cm_warp,
  input  logic                 wt_valid,
  input  logic [WID_W-1:0]     wt_warp,
  input  logic [GRP_W-2:0]     wt_n,
  input  logic                 rt_valid,
  input  logic [WID_W-1:0]     rt_warp,
  input  logic [TAG_W-1:0]     rt_tag,
  output logic                 cp_full,
  output logic [NUM_WARPS-1:0] stall,
  output logic                 rt_err
);

  logic [SLOTS-1:0] vld, vld_n;
  logic [CNT_W-1:0] cnt   [SLOTS];
  logic [CNT_W-1:0] cnt_n [SLOTS];
  logic [GRP_W-1:0] grp   [SLOTS];
  logic [GRP_W-1:0] grp_n [SLOTS];
  logic [TAG_W-1:0] tag   [SLOTS];
  logic [GRP_W-1:0] gidx   [NUM_WARPS];
  logic [GRP_W-1:0] gidx_n [NUM_WARPS];
  logic [GRP_W-1:0] mark   [NUM_WARPS];
  logic [GRP_W-1:0] mark_n [NUM_WARPS];
  logic [NUM_WARPS-1:0] stall_n;
  logic             err_n, hit, full_w, cp_take;
  logic [IDX_W-1:0] slot;

  wire cp_real = cp_valid && (|cp_mask) && (cp_reqs != '0);

  always_comb begin
    full_w = 1'b1;
    slot   = '0;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (!vld[IDX_W'(int'(cp_warp) * ENTRIES + e)]) begin
        full_w = 1'b0;
        slot   = IDX_W'(int'(cp_warp) * ENTRIES + e);
      end
    end
  end

  assign cp_full = cp_real && full_w;
  assign cp_take = cp_real && !full_w;

  always_comb begin
    logic [NUM_WARPS-1:0] arm;
    logic                 pend;
    logic [GRP_W-1:0]     age;
    vld_n  = vld;
    cnt_n  = cnt;
    grp_n  = grp;
    gidx_n = gidx;
    mark_n = mark;
    arm    = stall;
    hit    = 1'b0;
    if (rt_valid) begin
      for (int e = 0; e < ENTRIES; e++) begin
        if (!hit && vld[IDX_W'(int'(rt_warp) * ENTRIES + e)] &&
            tag[IDX_W'(int'(rt_warp) * ENTRIES + e)] == rt_tag) begin
          hit = 1'b1;
          cnt_n[IDX_W'(int'(rt_warp) * ENTRIES + e)] = cnt[IDX_W'(int'(rt_warp) * ENTRIES + e)] - 1'b1;
          if (cnt[IDX_W'(int'(rt_warp) * ENTRIES + e)] == CNT_W'(1))
            vld_n[IDX_W'(int'(rt_warp) * ENTRIES + e)] = 1'b0;
        end
      end
    end
    if (cp_take) begin
      vld_n[slot] = 1'b1;
      cnt_n[slot] = cp_reqs;
      grp_n[slot] = gidx[cp_warp];
    end
    if (cm_valid) gidx_n[cm_warp] = gidx[cm_warp] + 1'b1;
    if (wt_valid) begin
      mark_n[wt_warp] = gidx_n[wt_warp] - GRP_W'(wt_n);
      arm[wt_warp]    = 1'b1;
    end
    for (int w = 0; w < NUM_WARPS; w++) begin
      pend = 1'b0;
      for (int e = 0; e < ENTRIES; e++) begin
        age = mark_n[w] - grp_n[IDX_W'(w * ENTRIES + e)];
        if (vld_n[IDX_W'(w * ENTRIES + e)] && age != '0 && !age[GRP_W-1]) pend = 1'b1;
      end
      stall_n[w] = arm[w] && pend;
    end
    err_n = rt_valid && !hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld    <= '0;
      stall  <= '0;
      rt_err <= 1'b0;
      for (int w = 0; w < NUM_WARPS; w++) begin
        gidx[w] <= '0;
        mark[w] <= '0;
      end
      for (int i = 0; i < SLOTS; i++) begin
        cnt[i] <= '0;
        grp[i] <= '0;
        tag[i] <= '0;
      end
    end else begin
      vld    <= vld_n;
      cnt    <= cnt_n;
      grp    <= grp_n;
      gidx   <= gidx_n;
      mark   <= mark_n;
      stall  <= stall_n;
      rt_err <= err_n;
      if (cp_take) tag[slot] <= cp_tag;
    end
  end

endmodule

// File: rtl/async_copy_dep_tracker_chk.sv
module async_copy_dep_tracker_chk #(
  parameter int NUM_WARPS = 4,
  parameter int LANES     = 4,
  parameter int TAG_W     = 12,
  parameter int CNT_W     = 3,
  parameter int GRP_W     = 5,
  parameter int WID_W     = 2
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 cp_valid,
  input logic [LANES-1:0]     cp_mask,
  input logic [CNT_W-1:0]     cp_reqs,
  input logic                 wt_valid,
  input logic [WID_W-1:0]     wt_warp,
  input logic                 rt_valid,
  input logic [WID_W-1:0]     rt_warp,
  input logic                 cp_full,
  input logic [NUM_WARPS-1:0] stall,
  input logic                 rt_err
);

  AST_FULL_NEEDS_REAL_COPY: assert property (@(posedge clk) disable iff (rst)
    cp_full |-> (cp_valid && (|cp_mask) && cp_reqs != '0)); // R8

  AST_ERR_NEEDS_RETURN: assert property (@(posedge clk) disable iff (rst)
    rt_err |-> $past(rt_valid)); // R9

  AST_CLEAN_AFTER_RESET: assert property (@(posedge clk)
    $past(rst) |-> (stall == '0 && !rt_err)); // R1

  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
    AST_STALL_RISE_FROM_WAIT: assert property (@(posedge clk) disable iff (rst)
      $rose(stall[w]) |-> $past(wt_valid && wt_warp == WID_W'(w))); // R3

    AST_STALL_FALL_FROM_EVENT: assert property (@(posedge clk) disable iff (rst)
      $fell(stall[w]) |-> $past((rt_valid && rt_warp == WID_W'(w)) ||
                                (wt_valid && wt_warp == WID_W'(w)))); // R7
  end

endmodule

bind async_copy_dep_tracker async_copy_dep_tracker_chk #(
  .NUM_WARPS(NUM_WARPS), .LANES(LANES), .TAG_W(TAG_W),
  .CNT_W(CNT_W), .GRP_W(GRP_W), .WID_W(WID_W)
) u_chk (
  .clk(clk), .rst(rst), .cp_valid(cp_valid), .cp_mask(cp_mask), .cp_reqs(cp_reqs),
  .wt_valid(wt_valid), .wt_warp(wt_warp), .rt_valid(rt_valid), .rt_warp(rt_warp),
  .cp_full(cp_full), .stall(stall), .rt_err(rt_err)
);

// File: tb/tb_async_copy_dep_tracker.sv
module tb_async_copy_dep_tracker;
  localparam int NW = 4, NE = 8, LN = 4, TW = 12, CW = 3, GW = 5, WW = 2;

  logic clk = 0, rst = 1;
  logic cp_valid = 0, cm_valid = 0, wt_valid = 0, rt_valid = 0;
  logic [WW-1:0] cp_warp = 0, cm_warp = 0, wt_warp = 0, rt_warp = 0;
  logic [TW-1:0] cp_tag = 0, rt_tag = 0;
  logic [LN-1:0] cp_mask = 0;
  logic [CW-1:0] cp_reqs = 0;
  logic [GW-2:0] wt_n = 0;
  logic cp_full, rt_err;
  logic [NW-1:0] stall;

  always #4 clk = ~clk;

  async_copy_dep_tracker #(.NUM_WARPS(NW), .ENTRIES(NE), .LANES(LN), .TAG_W(TW),
    .CNT_W(CW), .GRP_W(GW)) dut (.*);

  typedef struct { int grp; int tag; int cnt; } ent_t;
  ent_t mq[NW][$];
  int   mg[NW], mmark[NW];
  bit   mstall[NW];
  bit   merr;
  int   checks = 0, fails = 0, cycles = 0, next_tag = 1;

  task automatic chk(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit exp_full();
    return cp_valid && cp_mask != 0 && cp_reqs != 0 && mq[cp_warp].size() >= NE;
  endfunction

  function automatic int exp_stall();
    int v = 0;
    for (int w = 0; w < NW; w++) if (mstall[w]) v |= (1 << w);
    return v;
  endfunction

  task automatic model_edge();
    bit hit = 0;
    bit take = cp_valid && cp_mask != 0 && cp_reqs != 0 && mq[cp_warp].size() < NE;
    if (rt_valid) begin
      for (int i = 0; i < mq[rt_warp].size(); i++) begin
        if (!hit && mq[rt_warp][i].tag == int'(rt_tag)) begin
          hit = 1;
          mq[rt_warp][i].cnt--;
          if (mq[rt_warp][i].cnt == 0) mq[rt_warp].delete(i);
        end
      end
    end
    merr = rt_valid && !hit;
    if (take) begin
      ent_t e;
      e.grp = mg[cp_warp]; e.tag = int'(cp_tag); e.cnt = int'(cp_reqs);
      mq[cp_warp].push_back(e);
    end
    if (cm_valid) mg[cm_warp]++;
    if (wt_valid) begin
      mmark[wt_warp] = mg[wt_warp] - int'(wt_n);
      mstall[wt_warp] = 1;
    end
    for (int w = 0; w < NW; w++) begin
      bit pend = 0;
      foreach (mq[w][i]) if (mq[w][i].grp < mmark[w]) pend = 1;
      if (!pend) mstall[w] = 0;
    end
  endtask

  task automatic idle_in();
    cp_valid = 0; cm_valid = 0; wt_valid = 0; rt_valid = 0;
  endtask

  task automatic step();
    #1;
    chk(cp_full, exp_full(), "R8");
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk(stall, exp_stall(), "R3/R7");
    chk(rt_err, merr, "R9");
    idle_in();
  endtask

  task automatic copy(input int w, input int t, input int reqs, input int mask);
    cp_valid = 1; cp_warp = WW'(w); cp_tag = TW'(t); cp_reqs = CW'(reqs); cp_mask = LN'(mask);
  endtask
  task automatic commit(input int w);
    cm_valid = 1; cm_warp = WW'(w);
  endtask
  task automatic waitg(input int w, input int n);
    wt_valid = 1; wt_warp = WW'(w); wt_n = (GW-1)'(n);
  endtask
  task automatic ret(input int w, input int t);
    rt_valid = 1; rt_warp = WW'(w); rt_tag = TW'(t);
  endtask

  initial begin
    while (cycles < 200000) begin
      @(posedge clk);
      cycles++;
    end
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int w = 0; w < NW; w++) begin mg[w] = 0; mmark[w] = 0; mstall[w] = 0; end
    merr = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: outputs after reset, empty table refuses nothing
    chk(stall, 0, "R1");
    chk(rt_err, 0, "R1");
    copy(0, 16'h11, 2, 4'hF); #1; chk(cp_full, 0, "R1");
    step();
    commit(0); step();
    copy(0, 16'h12, 1, 4'h3); step();
    commit(0); step();
    copy(0, 16'h13, 1, 4'h1); step();
    waitg(0, 1); step();
    chk(stall[0], 1, "R3");
    ret(0, 16'h12); step();
    chk(stall[0], 1, "R2");      // group 1 is among the allowed recent groups
    ret(0, 16'h11); step();
    chk(stall[0], 1, "R6");      // one of two requests still outstanding
    ret(0, 16'h11); step();
    chk(stall[0], 0, "R7");
    waitg(0, 0); step();
    chk(stall[0], 0, "R2");      // open group is never monitored
    waitg(0, 5); step();
    chk(stall[0], 0, "R4");
    commit(0); waitg(0, 0); step();
    chk(stall[0], 1, "R11");
    // R10: another warp stays free while warp 0 is held
    copy(1, 16'h21, 1, 4'h2); commit(1); waitg(1, 0); step();
    chk(stall[1], 1, "R11");
    chk(stall[0], 1, "R10");
    ret(0, 16'h13); step();
    chk(stall[0], 0, "R7");
    chk(stall[1], 1, "R10");
    ret(1, 16'h21); step();
    chk(stall[1], 0, "R7");
    copy(1, 16'h22, 2, 0); step();
    commit(1); waitg(1, 0); step();
    chk(stall[1], 0, "R5");
    copy(1, 16'h23, 0, 4'hF); commit(1); waitg(1, 0); step();
    chk(stall[1], 0, "R5");
    // R8: fill warp 2
    for (int k = 0; k < NE; k++) begin copy(2, 16'h31 + k, 1, 4'h1); step(); end
    copy(2, 16'h39, 1, 4'h1); #1; chk(cp_full, 1, "R8"); step();
    copy(2, 16'h3A, 1, 4'h0); #1; chk(cp_full, 0, "R5"); step();
    commit(2); waitg(2, 0); step();
    chk(stall[2], 1, "R3");
    ret(2, 16'h39); step();
    chk(rt_err, 1, "R8");        // refused copy left no entry
    step();
    chk(rt_err, 0, "R9");
    for (int k = 0; k < NE; k++) begin ret(2, 16'h31 + k); step(); end
    chk(stall[2], 0, "R7");
    // R12: many commits on warp 3 so the group index wraps
    for (int k = 0; k < 40; k++) begin
      copy(3, 16'h100 + k, 1, 4'h8); step();
      commit(3); step();
      waitg(3, 0); step();
      chk(stall[3], 1, "R12");
      ret(3, 16'h100 + k); step();
      chk(stall[3], 0, "R12");
    end
    next_tag = 16'h200;
    // random phase
    for (int c = 0; c < 3000; c++) begin
      if ($urandom_range(99) < 50) begin
        int w = $urandom_range(NW - 1);
        if (mq[w].size() > 0) ret(w, mq[w][$urandom_range(mq[w].size() - 1)].tag);
        else if ($urandom_range(99) < 5) ret(w, 16'hFFF);
      end
      begin
        int w = $urandom_range(NW - 1);
        int r = $urandom_range(3);
        if (!mstall[w]) begin
          if (r == 0) begin
            copy(w, next_tag, $urandom_range(3), ($urandom_range(7) == 0) ? 0 : $urandom_range(15));
            next_tag++;
            if (next_tag >= 16'hFF0) next_tag = 16'h200;
          end else if (r == 1) begin
            if (mq[w].size() == 0 || mg[w] - mq[w][0].grp < 12) commit(w);
          end else if (r == 2) begin
            waitg(w, $urandom_range(3));
          end
        end
      end
      step();
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule